// File: doc/BRIEF.md
# Radix-4 CORDIC Rotation Engine

This block rotates a two-dimensional vector by a given angle using circular CORDIC in rotation mode. It resolves two bits of angle per clock by choosing, at each step, a signed radix-4 digit whose magnitude is 0, 1 or 2. After a pulse on `start_i` it spends one cycle capturing the three operands. It then runs eight micro-rotations, paced by a 3-bit iteration counter, and raises `done_o` for one cycle. The x and y results are left unscaled. The gain depends on the digits chosen, so each digit magnitude is exported with a strobe while the rotation runs. A downstream compensation stage uses these digits to form the inverse gain.

Coordinates are 16-bit two's complement. The angle is 16-bit two's complement with 13 fraction bits, so one radian is 8192 units. The control is a four-state machine:
- `ST_IDLE` waits for `start_i` and then goes to `ST_LOAD`.
- `ST_LOAD` captures the operands and always goes to `ST_ROT`.
- `ST_ROT` stays while the counter is below 7 and goes to `ST_DONE` when the counter equals 7.
- `ST_DONE` returns to `ST_IDLE` unconditionally.

Top module: `r4_cordic_core`

## Requirements
- R1: After reset `busy_o`, `done_o` and `digit_vld_o` are low and `x_o`, `y_o` are zero.
- R2: A `start_i` sampled high in the idle state raises `busy_o` in the next cycle. The operands are captured at the end of that load cycle. `done_o` is high for exactly one cycle, beginning 9 clock edges after the edge that sampled `start_i`, and `busy_o` is low in that cycle.
- R3: `start_i` has no effect while `busy_o` or `done_o` is high: the running result is unchanged and no new operation begins.
- R4: Iteration i (i = 0..7) forms tx = x >>> 2i and ty = y >>> 2i, arithmetic on 16 bits, then scales both by the digit magnitude. If the residual angle z is non-negative (MSB 0) the update is x -= ty, y += tx, z -= table term. Otherwise all three signs are reversed. `x_o`, `y_o` equal this recurrence bit for bit.
- R5: The digit is selected from a window q = floor(z * 4^i / 1024), saturated to [-32, 31]. Let a = q for q >= 0 and a = -q-1 for q < 0. In iteration 0 the magnitude is 2 if a >= 7, 1 if a >= 3, and 0 otherwise. In later iterations it is 2 if a >= 12, 1 if a >= 4, and 0 otherwise.
- R6: The 2-bit digit code is 00 for magnitude 1, 01 for magnitude 2 and 10 for magnitude 0; 11 never appears. Code bit 0 doubles the shifted operand by a 1-bit left shift. Code bit 1 forces both shifted operands and the angle term to zero, so an angle of zero returns the input vector unchanged.
- R7: The angle term for iteration i and magnitude s in {1,2} is round(atan(s * 4^-i) * 8192). The table is addressed by {i, code bit 0}.
- R8: `digit_vld_o` is high for exactly 8 consecutive cycles per operation and at no other time. `digit_o` carries iteration 0 first, and each strobe comes on the cycle whose closing edge applies that digit.
- R9: `x_o` and `y_o` hold their values from `done_o` until the next operation's load edge, whatever the inputs do.
- R10: For |x|, |y| <= 8000 and |angle| <= 12868 (about pi/2), each result lies within 80 LSB of K * (x cos a - y sin a), or K * (y cos a + x sin a) for `y_o`. Here K is the product over i of sqrt(1 + s_i^2 * 16^-i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| x_i | input | 16 | Initial x coordinate |
| y_i | input | 16 | Initial y coordinate |
| z_i | input | 16 | Rotation angle, 8192 units per radian |
| busy_o | output | 1 | High during the load and rotation cycles |
| done_o | output | 1 | One-cycle completion pulse |
| x_o | output | 16 | Unscaled rotated x |
| y_o | output | 16 | Unscaled rotated y |
| digit_o | output | 2 | Digit code of the current iteration |
| digit_vld_o | output | 1 | Qualifies `digit_o` |

## Verification
The bench goes after the selection thresholds with negative angles. A design that took the magnitude of a negative window as -q instead of -q-1 would pick a different digit near a boundary, and the exported digit sequence would diverge from the model. A zero angle must pass the vector through untouched; a design that ignored the zero code would add a shifted term and corrupt the result. The largest angles near plus and minus pi/2 exercise the doubled digit in iteration 0, where a wrong table address or a missing doubling leaves a residual far outside the accuracy bound. Start pulses during the run and in the done cycle would, if not blocked, restart the engine and either change the result or stretch `busy_o`.

// File: rtl/r4_cordic_pkg.sv
package r4_cordic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_ROT  = 2'd2,
        ST_DONE = 2'd3
    } r4_state_e;

    // digit codes: bit0 = double, bit1 = zero
    localparam logic [1:0] DIG_ONE  = 2'b00;
    localparam logic [1:0] DIG_TWO  = 2'b01;
    localparam logic [1:0] DIG_ZERO = 2'b10;

    // selection window width and thresholds
    localparam int WIN_W      = 6;
    localparam int TH0_TWO    = 7;
    localparam int TH0_ONE    = 3;
    localparam int THN_TWO    = 12;
    localparam int THN_ONE    = 4;

endpackage

// File: rtl/r4_digit_sel.sv
module r4_digit_sel
    import r4_cordic_pkg::*;
#(
    parameter int ZW    = 16,
    parameter int CNT_W = 3
) (
    input  logic signed [ZW-1:0]    z_i,
    input  logic        [CNT_W-1:0] cnt_i,
    output logic        [1:0]       digit_o
);
    localparam int ITERS  = 1 << CNT_W;
    localparam int WIDE_W = ZW + 2 * ITERS;
    localparam int DROP   = ZW - WIN_W;
    localparam logic signed [WIDE_W-1:0] SAT_HI = (1 <<< (WIN_W - 1)) - 1;
    localparam logic signed [WIDE_W-1:0] SAT_LO = -(1 <<< (WIN_W - 1));

    logic signed [WIDE_W-1:0] wide;
    logic signed [WIDE_W-1:0] q;
    logic        [WIN_W-1:0]  win;
    logic        [WIN_W-2:0]  mag_a;
    logic        [1:0]        cand_first;
    logic        [1:0]        cand_rest;
    logic                     use_first;

    always_comb begin
        wide = {{(WIDE_W-ZW){z_i[ZW-1]}}, z_i} <<< {cnt_i, 1'b0};
        q    = wide >>> DROP;
        if (q > SAT_HI)      win = SAT_HI[WIN_W-1:0];
        else if (q < SAT_LO) win = SAT_LO[WIN_W-1:0];
        else                 win = q[WIN_W-1:0];
        mag_a = win[WIN_W-1] ? ~win[WIN_W-2:0] : win[WIN_W-2:0];
    end

    // candidate for the first, non-linear iteration
    always_comb begin
        if (int'(mag_a) >= TH0_TWO)      cand_first = DIG_TWO;
        else if (int'(mag_a) >= TH0_ONE) cand_first = DIG_ONE;
        else                             cand_first = DIG_ZERO;
    end

    // candidate for the remaining iterations
    always_comb begin
        if (int'(mag_a) >= THN_TWO)      cand_rest = DIG_TWO;
        else if (int'(mag_a) >= THN_ONE) cand_rest = DIG_ONE;
        else                             cand_rest = DIG_ZERO;
    end

    assign use_first = (cnt_i == '0);
    assign digit_o   = use_first ? cand_first : cand_rest;

endmodule

// File: rtl/r4_angle_rom.sv
module r4_angle_rom #(
    parameter int ZW    = 16,
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [1:0]       digit_i,
    output logic [ZW-1:0]    angle_o
);
    // entries scaled for 8192 units per radian
    logic [CNT_W:0] addr;
    logic [ZW-1:0]  raw;

    assign addr = {cnt_i, digit_i[0]};

    always_comb begin
        unique case (addr)
            4'd0:  raw = ZW'(6434);
            4'd1:  raw = ZW'(9070);
            4'd2:  raw = ZW'(2007);
            4'd3:  raw = ZW'(3798);
            4'd4:  raw = ZW'(511);
            4'd5:  raw = ZW'(1019);
            4'd6:  raw = ZW'(128);
            4'd7:  raw = ZW'(256);
            4'd8:  raw = ZW'(32);
            4'd9:  raw = ZW'(64);
            4'd10: raw = ZW'(8);
            4'd11: raw = ZW'(16);
            4'd12: raw = ZW'(2);
            4'd13: raw = ZW'(4);
            4'd14: raw = ZW'(0);
            default: raw = ZW'(1);
        endcase
    end

    // and-array: zero digit kills the angle term
    assign angle_o = raw & {ZW{~digit_i[1]}};

endmodule

// File: rtl/r4_lane.sv
module r4_lane #(
    parameter int W         = 16,
    parameter int SHW       = 4,
    parameter bit SUB_ON_POS = 1'b1
) (
    input  logic signed [W-1:0]   own_i,
    input  logic signed [W-1:0]   other_i,
    input  logic        [SHW-1:0] sh_i,
    input  logic        [1:0]     digit_i,
    input  logic                  pos_i,
    output logic signed [W-1:0]   next_o
);
    logic signed [W-1:0] shifted;
    logic signed [W-1:0] scaled;
    logic signed [W-1:0] term;
    logic                do_sub;

    always_comb begin
        shifted = other_i >>> sh_i;
        scaled  = digit_i[0] ? (shifted <<< 1) : shifted;
        term    = digit_i[1] ? '0 : scaled;
        do_sub  = SUB_ON_POS ? pos_i : ~pos_i;
        next_o  = do_sub ? (own_i - term) : (own_i + term);
    end

endmodule

// File: rtl/r4_ctrl.sv
module r4_ctrl
    import r4_cordic_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             load_en_o,
    output logic             iter_en_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

    r4_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (state_q == ST_LOAD) cnt_q <= '0;
        else if (state_q == ST_ROT)  cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_ROT;
            ST_ROT:  if (cnt_q == LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_en_o = 1'b0;
        iter_en_o = 1'b0;
        busy_o    = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: begin load_en_o = 1'b1; busy_o = 1'b1; end
            ST_ROT:  begin iter_en_o = 1'b1; busy_o = 1'b1; end
            ST_DONE: done_o = 1'b1;
        endcase
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/r4_cordic_core.sv
module r4_cordic_core
    import r4_cordic_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [W-1:0]  x_i,
    input  logic [W-1:0]  y_i,
    input  logic [W-1:0]  z_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [W-1:0]  x_o,
    output logic [W-1:0]  y_o,
    output logic [1:0]    digit_o,
    output logic          digit_vld_o
);
    localparam int SHW = CNT_W + 1;

    logic [CNT_W-1:0]    cnt;
    logic                load_en, iter_en;
    logic signed [W-1:0] xr, yr, zr;
    logic signed [W-1:0] lane_next [2];
    logic signed [W-1:0] zn;
    logic [W-1:0]        angle;
    logic [1:0]          digit;
    logic                pos;
    logic [SHW-1:0]      sh;

    r4_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cnt_o(cnt),
        .load_en_o(load_en), .iter_en_o(iter_en), .busy_o(busy_o), .done_o(done_o)
    );

    r4_digit_sel #(.ZW(W), .CNT_W(CNT_W)) u_sel (
        .z_i(zr), .cnt_i(cnt), .digit_o(digit)
    );

    r4_angle_rom #(.ZW(W), .CNT_W(CNT_W)) u_rom (
        .cnt_i(cnt), .digit_i(digit), .angle_o(angle)
    );

    assign pos = ~zr[W-1];
    assign sh  = {cnt, 1'b0};

    // lane 0 updates x from y, lane 1 updates y from x
    for (genvar g = 0; g < 2; g++) begin : g_lane
        r4_lane #(.W(W), .SHW(SHW), .SUB_ON_POS(g == 0)) u_lane (
            .own_i  (g == 0 ? xr : yr),
            .other_i(g == 0 ? yr : xr),
            .sh_i   (sh),
            .digit_i(digit),
            .pos_i  (pos),
            .next_o (lane_next[g])
        );
    end

    assign zn = pos ? (zr - $signed(angle)) : (zr + $signed(angle));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xr <= '0;
            yr <= '0;
            zr <= '0;
        end else if (load_en) begin
            xr <= x_i;
            yr <= y_i;
            zr <= z_i;
        end else if (iter_en) begin
            xr <= lane_next[0];
            yr <= lane_next[1];
            zr <= zn;
        end
    end

    assign x_o         = xr;
    assign y_o         = yr;
    assign digit_o     = digit;
    assign digit_vld_o = iter_en;

endmodule

// File: rtl/r4_cordic_chk.sv
module r4_cordic_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] x_o,
    input logic [W-1:0] y_o,
    input logic [1:0]   digit_o,
    input logic         digit_vld_o
);
    logic [3:0] vld_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           vld_cnt <= '0;
        else if (done_o)      vld_cnt <= '0;
        else if (digit_vld_o) vld_cnt <= vld_cnt + 1'b1;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R2
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy_o && done_o)); // R2
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o && !done_o) |=> busy_o); // R2
    AST_DONE_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !busy_o); // R3
    AST_DIGIT_CODE: assert property (@(posedge clk) disable iff (!rst_n) digit_vld_o |-> (digit_o != 2'b11)); // R6
    AST_VLD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) digit_vld_o |-> busy_o); // R8
    AST_EIGHT_DIGITS: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (vld_cnt == 4'd8)); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |=> ($stable(x_o) && $stable(y_o))); // R9

endmodule

bind r4_cordic_core r4_cordic_chk #(.W(W)) i_chk (.*);

// File: tb/test_r4_cordic_core.sv
module test_r4_cordic_core;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] x_in = '0, y_in = '0, z_in = '0;
    logic        busy, done, dvld;
    logic [15:0] x_out, y_out;
    logic [1:0]  dig;

    int total = 0;
    int bad   = 0;
    int tab [16];

    always #4 clk = ~clk;

    r4_cordic_core i_r4_cordic_core (
        .clk(clk), .rst_n(rst_n), .start_i(start), .x_i(x_in), .y_i(y_in), .z_i(z_in),
        .busy_o(busy), .done_o(done), .x_o(x_out), .y_o(y_out),
        .digit_o(dig), .digit_vld_o(dvld)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // bit-accurate recurrence from R4..R7
    task automatic model(input logic signed [15:0] x0, y0, z0,
                         output logic signed [15:0] xo, yo, output logic [15:0] dg);
        logic signed [15:0] x, y, z, tx, ty, ta;
        longint q, a;
        int mag;
        logic [1:0] code;
        x = x0; y = y0; z = z0; dg = '0;
        for (int i = 0; i < 8; i++) begin
            q = (longint'(z) <<< (2 * i)) >>> 10;
            if (q > 31) q = 31;
            if (q < -32) q = -32;
            a = (q < 0) ? -q - 1 : q;
            if (i == 0) mag = (a >= 7) ? 2 : (a >= 3) ? 1 : 0;
            else        mag = (a >= 12) ? 2 : (a >= 4) ? 1 : 0;
            code = (mag == 0) ? 2'b10 : (mag == 2) ? 2'b01 : 2'b00;
            dg[2*i +: 2] = code;
            tx = x >>> (2 * i);
            ty = y >>> (2 * i);
            if (mag == 2) begin tx = tx <<< 1; ty = ty <<< 1; end
            if (mag == 0) begin tx = '0; ty = '0; ta = '0; end
            else ta = 16'(tab[2 * i + (mag == 2 ? 1 : 0)]);
            if (!z[15]) begin x = x - ty; y = y + tx; z = z - ta; end
            else        begin x = x + ty; y = y - tx; z = z + ta; end
        end
        xo = x; yo = y;
    endtask

    task automatic run_op(input logic signed [15:0] xa, ya, za, input bit check_acc);
        logic signed [15:0] ex, ey;
        logic [15:0] ed, gd;
        int lat, nd, busy_miss;
        real k, th, rx, ry, dx, dy;
        model(xa, ya, za, ex, ey, ed);
        @(negedge clk);
        x_in = xa; y_in = ya; z_in = za; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = -1; nd = 0; busy_miss = 0; gd = '0;
        for (int c = 0; c < 14; c++) begin
            if (dvld) begin
                if (nd < 8) gd[2*nd +: 2] = dig;
                nd++;
            end
            if (done && lat < 0) lat = c;
            if (c < 9 && !busy) busy_miss++;
            if (c == 9 && busy) busy_miss++;
            @(negedge clk);
        end
        chk("R2 latency", lat, 9);
        chk("R2 busy window", busy_miss, 0);
        chk("R8 digit count", nd, 8);
        chk("R5 digit sequence", gd, ed);
        chk("R4 x result", $signed(x_out), ex);
        chk("R4 y result", $signed(y_out), ey);
        if (check_acc) begin
            k = 1.0;
            for (int i = 0; i < 8; i++) begin
                int m;
                m = (ed[2*i +: 2] == 2'b10) ? 0 : (ed[2*i +: 2] == 2'b01) ? 2 : 1;
                k = k * $sqrt(1.0 + (m * m) / (16.0 ** i));
            end
            th = real'(za) / 8192.0;
            rx = k * (real'(xa) * $cos(th) - real'(ya) * $sin(th));
            ry = k * (real'(ya) * $cos(th) + real'(xa) * $sin(th));
            dx = real'($signed(x_out)) - rx; if (dx < 0) dx = -dx;
            dy = real'($signed(y_out)) - ry; if (dy < 0) dy = -dy;
            chk("R10 x accuracy", (dx <= 80.0), 1);
            chk("R10 y accuracy", (dy <= 80.0), 1);
        end
    endtask

    task automatic t_reset();
        #1;
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 digit valid", dvld, 0);
        chk("R1 x", x_out, 0);
        chk("R1 y", y_out, 0);
    endtask

    task automatic t_zero_angle();
        run_op(16'sd5000, -16'sd3000, 16'sd0, 1'b0);
        chk("R6 zero angle keeps x", $signed(x_out), 5000);
        chk("R6 zero angle keeps y", $signed(y_out), -3000);
    endtask

    task automatic t_sweep();
        run_op(16'sd7000, 16'sd0, 16'sd4289, 1'b1);
        run_op(16'sd7000, 16'sd0, -16'sd4289, 1'b1);
        run_op(16'sd6000, 16'sd2500, 16'sd12868, 1'b1);
        run_op(-16'sd4000, 16'sd8000, -16'sd12868, 1'b1);
        run_op(16'sd8000, -16'sd8000, 16'sd3200, 1'b1);
        run_op(16'sd1234, 16'sd4321, -16'sd7800, 1'b1);
        run_op(16'sd7999, 16'sd100, 16'sd7750, 1'b1); // R7 near doubled-digit boundary
        run_op(-16'sd7999, -16'sd5, 16'sd25, 1'b1);
    endtask

    task automatic t_ignore_start();
        logic signed [15:0] ex, ey;
        logic [15:0] ed;
        model(16'sd3000, 16'sd2000, 16'sd5000, ex, ey, ed);
        @(negedge clk);
        x_in = 16'sd3000; y_in = 16'sd2000; z_in = 16'sd5000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        x_in = -16'sd6000; y_in = 16'sd100; z_in = -16'sd9000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R3 no restart after done", busy, 0);
        chk("R3 x unaffected", $signed(x_out), ex);
        chk("R3 y unaffected", $signed(y_out), ey);
        repeat (3) @(negedge clk);
        chk("R3 still idle", busy, 0);
    endtask

    task automatic t_hold();
        logic [15:0] hx, hy;
        hx = x_out; hy = y_out;
        x_in = 16'h1111; y_in = 16'h2222; z_in = 16'h0333;
        repeat (5) @(negedge clk);
        chk("R9 x held", x_out, hx);
        chk("R9 y held", y_out, hy);
    endtask

    initial begin
        #1_600_000;
        total++; bad++;
        $display("FAIL watchdog expired: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int j = 0; j < 16; j++)
            tab[j] = $rtoi($atan(((j & 1) != 0 ? 2.0 : 1.0) / (4.0 ** (j >> 1))) * 8192.0 + 0.5);
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_zero_angle();
        t_sweep();
        t_ignore_start();
        t_hold();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule